// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block holds the modem-status view of a UART. It watches four active-low modem pins (clear-to-send, data-set-ready, ring indicator and carrier detect), resynchronises them, and presents an 8-bit status word. The upper nibble gives the asserted state of each line. The lower nibble holds sticky change flags. A read strobe from the register interface clears the flags. While any flag is set and the modem-status interrupt enable is on, the block raises an interrupt request.

In loopback mode the line states come from the modem-control output bits instead of the pins. The pins are then ignored. With automatic CTS flow control enabled, a deasserted clear-to-send line produces a transmit-hold signal. That signal takes effect only at a character boundary, reported by the shifter, or while the transmitter is idle. Reasserting clear-to-send lifts the hold.

Top module: `msr_modem_status`

## Requirements
- R1: After reset the status word reads 0x00 (with all pins high), the interrupt request is low and the transmit hold is low. All change flags are clear, and the first cycle after reset only loads the edge history, so no flag is set by it.
- R2: In normal mode, status bit 7 is the inverse of the carrier-detect pin, bit 6 of the ring pin, bit 5 of the data-set-ready pin and bit 4 of the clear-to-send pin. A pin change shows in the status word two clock edges later.
- R3: In loopback mode, bit 4 equals control bit 1 (request-to-send), bit 5 equals control bit 0 (data-terminal-ready), bit 6 equals control bit 2 and bit 7 equals control bit 3. The word follows the control bits in the same cycle, and the pins have no effect.
- R4: Bit 3 (carrier-detect change) is set one edge after status bit 7 changes in either direction.
- R5: Bit 0 (clear-to-send change) and bit 1 (data-set-ready change) are set one edge after status bit 4 or bit 5 changes in either direction. This also applies when the change comes from loopback.
- R6: Bit 2 (ring change) is set only when status bit 6 goes from 1 to 0. A 0-to-1 change leaves it clear.
- R7: A cycle with the read strobe high clears all change flags at the next edge. Flags stay set without a read.
- R8: A change detected in the same cycle as a read sets its flag at that edge, while the other flags clear.
- R9: The interrupt request equals the interrupt-enable input ANDed with the OR of the four change flags. It responds combinationally to the enable.
- R10: With auto-CTS enabled and status bit 4 at 0, the transmit hold rises at the edge after a cycle with the character-done strobe or the idle input high. It never rises in a cycle without one of them.
- R11: The transmit hold falls at the edge after status bit 4 returns to 1, or at the edge after auto-CTS is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| cd_ni | input | 1 | Carrier detect pin, active low |
| rd_i | input | 1 | Status register read strobe |
| loop_i | input | 1 | Loopback mode select |
| mcr_out_i | input | 4 | Modem control outputs: 0 DTR, 1 RTS, 2 and 3 general outputs |
| ier_ms_i | input | 1 | Modem-status interrupt enable |
| efr_autocts_i | input | 1 | Automatic CTS flow control enable |
| char_done_i | input | 1 | Strobe at the end of a transmitted character |
| tx_idle_i | input | 1 | Transmitter has nothing in flight |
| status_o | output | 8 | Status word: line states in 7:4, change flags in 3:0 |
| irq_o | output | 1 | Modem-status interrupt request |
| tx_hold_o | output | 1 | Hold request to the transmitter |

## Verification
A pin change reaches the status nibble two edges after it is driven. The matching flag, the interrupt and the transmit hold follow one edge later. Loopback values and the interrupt-enable gating appear in the cycle they are driven, and a read clears the flags one edge later. Every stimulus task therefore queues its expected values stamped with the exact cycle they are due, using those latencies. The monitor compares each value in its due cycle, a little after the falling edge. It also checks that the value does not appear early, by queuing the old value for the cycle before.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned WORD_W    = 2 * NUM_LINES;

  typedef enum int unsigned {
    LN_CTS = 0,
    LN_DSR = 1,
    LN_RI  = 2,
    LN_CD  = 3
  } line_e;

  typedef struct packed {
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] delta;
  } msr_word_t;

  // lines whose flag fires only on a 1 -> 0 status change
  localparam logic [NUM_LINES-1:0] FALL_ONLY = 4'b0100;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
  parameter int unsigned       WIDTH     = 4,
  parameter logic [WIDTH-1:0]  FALL_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic             primed_q;
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    if (FALL_MASK[i]) begin : g_fall
      assign hit[i] = primed_q & prev_q[i] & ~level_i[i];
    end else begin : g_any
      assign hit[i] = primed_q & (prev_q[i] ^ level_i[i]);
    end
  end

  // history follows the level every cycle; first cycle after reset only loads it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      prev_q   <= '0;
    end else begin
      primed_q <= 1'b1;
      prev_q   <= level_i;
    end
  end

  // a hit in the read cycle survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= '0;
    else if (clr_i) flag_q <= hit;
    else            flag_q <= flag_q | hit;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/msr_autocts.sv
module msr_autocts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cts_level_i,
  input  logic boundary_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hold_q <= 1'b0;
    else if (!en_i || cts_level_i) hold_q <= 1'b0;
    else if (boundary_i)           hold_q <= 1'b1;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/msr_modem_status.sv
module msr_modem_status
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cts_ni,
  input  logic                 dsr_ni,
  input  logic                 ri_ni,
  input  logic                 cd_ni,
  input  logic                 rd_i,
  input  logic                 loop_i,
  input  logic [3:0]           mcr_out_i,
  input  logic                 ier_ms_i,
  input  logic                 efr_autocts_i,
  input  logic                 char_done_i,
  input  logic                 tx_idle_i,
  output logic [WORD_W-1:0]    status_o,
  output logic                 irq_o,
  output logic                 tx_hold_o
);
  logic [NUM_LINES-1:0] pins_n, pins_sync_n, pin_level, loop_level, level, flags;
  msr_word_t            word;

  assign pins_n[LN_CTS] = cts_ni;
  assign pins_n[LN_DSR] = dsr_ni;
  assign pins_n[LN_RI]  = ri_ni;
  assign pins_n[LN_CD]  = cd_ni;

  msr_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_n),
    .q_o   (pins_sync_n)
  );

  assign pin_level = ~pins_sync_n;

  // loopback routing: RTS->CTS, DTR->DSR, out1->RI, out2->CD
  assign loop_level[LN_CTS] = mcr_out_i[1];
  assign loop_level[LN_DSR] = mcr_out_i[0];
  assign loop_level[LN_RI]  = mcr_out_i[2];
  assign loop_level[LN_CD]  = mcr_out_i[3];

  assign level = loop_i ? loop_level : pin_level;

  msr_delta #(
    .WIDTH    (NUM_LINES),
    .FALL_MASK(FALL_ONLY)
  ) u_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level),
    .clr_i  (rd_i),
    .flag_o (flags)
  );

  msr_autocts u_autocts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (efr_autocts_i),
    .cts_level_i(level[LN_CTS]),
    .boundary_i (char_done_i | tx_idle_i),
    .hold_o     (tx_hold_o)
  );

  assign word.level = level;
  assign word.delta = flags;
  assign status_o   = word;
  assign irq_o      = ier_ms_i & (|flags);
endmodule

// File: rtl/msr_modem_status_chk.sv
module msr_modem_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cts_ni,
  input logic       dsr_ni,
  input logic       ri_ni,
  input logic       cd_ni,
  input logic       rd_i,
  input logic       loop_i,
  input logic [3:0] mcr_out_i,
  input logic       ier_ms_i,
  input logic       efr_autocts_i,
  input logic       char_done_i,
  input logic       tx_idle_i,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic       tx_hold_o
);
  p_loop_map_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |-> status_o[7:4] == {mcr_out_i[3], mcr_out_i[2], mcr_out_i[0], mcr_out_i[1]});

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && status_o[3:0] != 4'h0) |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));

  p_irq_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ier_ms_i);

  p_irq_on_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_ms_i && status_o[3:0] != 4'h0) |-> irq_o);

  p_hold_boundary_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_hold_o) |-> $past(char_done_i || tx_idle_i));

  p_hold_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !efr_autocts_i |=> !tx_hold_o);
endmodule

bind msr_modem_status msr_modem_status_chk u_chk (.*);

// File: tb/msr_modem_status_test.sv
module msr_modem_status_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cts_ni = 1'b1, dsr_ni = 1'b1, ri_ni = 1'b1, cd_ni = 1'b1;
  logic       rd_i = 1'b0, loop_i = 1'b0, ier_ms_i = 1'b1, efr_autocts_i = 1'b0;
  logic       char_done_i = 1'b0, tx_idle_i = 1'b0;
  logic [3:0] mcr_out_i = 4'h0;
  logic [7:0] status_o;
  logic       irq_o, tx_hold_o;

  msr_modem_status uut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    int        due;
    int        sel;   // 0 status, 1 irq, 2 hold
    logic [7:0] exp;
    logic [7:0] mask;
    string     req;
  } item_t;

  item_t q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic expect_at(int dly, int sel, logic [7:0] exp, logic [7:0] mask, string req);
    item_t it;
    int pos;
    it.due = cyc + dly; it.sel = sel; it.exp = exp; it.mask = mask; it.req = req;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) if (q[i].due > it.due) begin pos = i; break; end
    q.insert(pos, it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_read(logic [7:0] exp_after, string req);
    rd_i = 1'b1;
    expect_at(1, 0, exp_after, 8'hFF, req);
    tick(1);
    rd_i = 1'b0;
  endtask

  // monitor: compare each item in its due cycle, just after the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = (it.sel == 0) ? status_o : (it.sel == 1) ? {7'd0, irq_o} : {7'd0, tx_hold_o};
        n_cmp++;
        if (it.due < cyc || ((act & it.mask) !== (it.exp & it.mask))) begin
          n_bad++;
          $display("FAIL %s sel=%0d cyc=%0d actual=%02h expected=%02h mask=%02h",
                   it.req, it.sel, cyc, act, it.exp, it.mask);
        end
      end
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(3);
    // R1 reset state
    expect_at(0, 0, 8'h00, 8'hFF, "R1");
    expect_at(0, 1, 8'h00, 8'hFF, "R1");
    expect_at(0, 2, 8'h00, 8'hFF, "R1");
    tick(1);
    // R2/R5/R9 CTS asserts
    cts_ni = 1'b0;
    expect_at(1, 0, 8'h00, 8'h10, "R2");
    expect_at(2, 0, 8'h10, 8'h10, "R2");
    expect_at(2, 0, 8'h00, 8'h0F, "R5");
    expect_at(3, 0, 8'h11, 8'hFF, "R5");
    expect_at(3, 1, 8'h01, 8'hFF, "R9");
    tick(5);
    do_read(8'h10, "R7");
    expect_at(1, 1, 8'h00, 8'hFF, "R9");
    tick(3);
    // R4 carrier detect
    cd_ni = 1'b0;
    expect_at(2, 0, 8'h90, 8'hFF, "R2");
    expect_at(3, 0, 8'h98, 8'hFF, "R4");
    tick(5);
    expect_at(0, 0, 8'h98, 8'hFF, "R7");
    do_read(8'h90, "R7");
    tick(3);
    // R6 ring: status rising gives no flag
    ri_ni = 1'b0;
    expect_at(2, 0, 8'hD0, 8'hFF, "R2");
    expect_at(3, 0, 8'hD0, 8'hFF, "R6");
    expect_at(3, 1, 8'h00, 8'hFF, "R6");
    tick(5);
    ri_ni = 1'b1;
    expect_at(3, 0, 8'h94, 8'hFF, "R6");
    expect_at(3, 1, 8'h01, 8'hFF, "R9");
    tick(5);
    do_read(8'h90, "R7");
    tick(3);
    // R5 DSR with interrupt disabled
    dsr_ni = 1'b0;
    ier_ms_i = 1'b0;
    expect_at(3, 0, 8'hB2, 8'hFF, "R5");
    expect_at(3, 1, 8'h00, 8'hFF, "R9");
    tick(5);
    ier_ms_i = 1'b1;
    expect_at(0, 1, 8'h01, 8'hFF, "R9");
    tick(1);
    do_read(8'hB0, "R7");
    tick(3);
    // R8 edge in the read cycle
    dsr_ni = 1'b1;
    expect_at(3, 0, 8'h92, 8'hFF, "R5");
    tick(5);
    cts_ni = 1'b1;
    tick(2);
    expect_at(0, 0, 8'h82, 8'hFF, "R2");
    do_read(8'h81, "R8");
    tick(3);
    do_read(8'h80, "R7");
    tick(3);
    // R3 loopback
    loop_i = 1'b1;
    mcr_out_i = 4'b0000;
    expect_at(0, 0, 8'h00, 8'hF0, "R3");
    tick(1);
    mcr_out_i = 4'b0010;
    expect_at(0, 0, 8'h10, 8'hF0, "R3");
    expect_at(1, 0, 8'h01, 8'h01, "R5");
    tick(1);
    mcr_out_i = 4'b1101;
    expect_at(0, 0, 8'hE0, 8'hF0, "R3");
    tick(1);
    cd_ni = 1'b1; cts_ni = 1'b0; ri_ni = 1'b0;
    expect_at(2, 0, 8'hE0, 8'hF0, "R3");
    expect_at(3, 0, 8'hE0, 8'hF0, "R3");
    tick(4);
    mcr_out_i = 4'b0000;
    loop_i = 1'b0;
    expect_at(0, 0, 8'h50, 8'hF0, "R2");
    tick(3);
    do_read(8'h50, "R7");
    tick(3);
    ri_ni = 1'b1;
    tick(5);
    do_read(8'h10, "R7");
    tick(3);
    // R10/R11 auto-CTS
    efr_autocts_i = 1'b1;
    expect_at(1, 2, 8'h00, 8'hFF, "R10");
    tick(2);
    cts_ni = 1'b1;
    expect_at(3, 2, 8'h00, 8'hFF, "R10");
    tick(5);
    expect_at(0, 2, 8'h00, 8'hFF, "R10");
    char_done_i = 1'b1;
    expect_at(1, 2, 8'h01, 8'hFF, "R10");
    tick(1);
    char_done_i = 1'b0;
    tick(2);
    expect_at(0, 2, 8'h01, 8'hFF, "R10");
    cts_ni = 1'b0;
    expect_at(2, 2, 8'h01, 8'hFF, "R11");
    expect_at(3, 2, 8'h00, 8'hFF, "R11");
    tick(5);
    tx_idle_i = 1'b1;
    cts_ni = 1'b1;
    expect_at(2, 2, 8'h00, 8'hFF, "R10");
    expect_at(3, 2, 8'h01, 8'hFF, "R10");
    tick(5);
    efr_autocts_i = 1'b0;
    expect_at(1, 2, 8'h00, 8'hFF, "R11");
    tick(3);
    tx_idle_i = 1'b0;
    cts_ni = 1'b0;
    tick(5);
    while (q.size() > 0) tick(1);
    tick(2);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule